// File: doc/BRIEF.md
# Self-timed successive-approximation controller with shrinking settle window

This block runs the binary search of a successive-approximation converter. It drives trial codes to a capacitor DAC and asks an external comparator for a verdict on each code. The converter is self-timed, and the block models that timing with a fast synchronous clock. After each verdict the block waits a number of clock cycles before it raises the next comparison request. This wait gives the control logic time to prepare the next trial and gives the DAC output time to settle on the new code.

The wait has two parts. The first is a fixed count for the control logic. The second is a settling count drawn from a chain of equal delay taps. The full chain is sized for the most significant capacitor. In shrinking mode one tap is switched off each time a bit is resolved, so the settling time falls toward the least significant bits. A programmable minimum stops the wait from dropping too low, because switching overshoot is the same size on every capacitor and so matters most on the small ones. In worst-case mode no tap is ever switched off, and every bit gets the full chain.

A start pulse begins a conversion, and a start pulse during a conversion restarts it. When the last bit is decided, a one-cycle done strobe is raised together with the result. A counter reports how many clock cycles the conversion took, so the two modes can be compared directly.

Top module: `sar_settle_ctrl`

## Requirements
- R1: A start pulse sampled at a clock edge makes busy 1, sets the trial code to MSB-only (bit NBITS-1 set, all others 0) and clears conv_cycles to 0, all visible after that edge.
- R2: After the start edge, or after each accepted verdict that is not the last, cmp_req stays low for exactly W clock cycles. It then rises and stays high until a verdict is accepted. W = FIXED_CYC + V, where V is the settling count for the bit under test.
- R3: In shrinking mode, with s bits already resolved, V = max((NBITS - s) * TAP_CYC, FLOOR_CYC).
- R4: In worst-case mode, V = NBITS * TAP_CYC for every bit.
- R5: A verdict is accepted when cmp_valid is 1 while cmp_req is 1. A cmp_result of 1 means the input is at or above the trial code, and the bit under test is kept; a cmp_result of 0 clears that bit. The next lower bit is then set as the new trial. Bits are decided from MSB to LSB.
- R6: On the edge that accepts the LSB verdict, done becomes 1 for exactly one cycle and result shows the final code. result then holds that code until the next conversion completes.
- R7: A cmp_valid that arrives while the settling wait is still running is ignored. The trial code, the verdicts and the timing do not change.
- R8: A start pulse during a conversion abandons it and begins a fresh conversion with the full settling chain.
- R9: After done, conv_cycles equals the number of clock edges from the start edge to the done edge. For the same input, shrinking mode needs fewer cycles than worst-case mode.
- R10: The mode input is sampled only at start. Changing it during a conversion has no effect on that conversion's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast modelling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin (or restart) a conversion |
| mode_shrink | input | 1 | 1: shrinking settle window, 0: worst-case window for every bit |
| cmp_valid | input | 1 | Comparator verdict is ready |
| cmp_result | input | 1 | Comparator verdict, 1 = input at or above trial code |
| cmp_req | output | 1 | Request for a comparison of the current trial code |
| dac_code | output | NBITS | Trial code driven to the DAC |
| busy | output | 1 | A conversion is in progress |
| done | output | 1 | One-cycle strobe when the LSB is decided |
| result | output | NBITS | Final code of the last completed conversion |
| conv_cycles | output | CYCW | Clock edges spent by the current or last conversion |

## Verification
The bench builds the block with a 6-bit search, one fixed cycle, two cycles per tap and a minimum of five settling cycles. With these values the minimum takes effect on the last two bits, so one run shows the shrinking steps and the clamp together. The small width lets the bench convert every possible input level in both modes. For each level it measures every settling window against the arithmetic formula, then checks the final code and the total cycle count. A subset of conversions adds early comparator strobes carrying the wrong verdict and flips the mode input mid-flight, and a separate run restarts a conversion halfway through.

// File: rtl/sar_settle_pkg.sv
package sar_settle_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_ASK    = 2'd2
  } sar_state_e;

  // Total wait before a comparison request: fixed part plus the settling
  // part taken from the live taps, clamped from below by the minimum.
  function automatic int unsigned wait_span(input int unsigned live_taps,
                                            input int unsigned tap_cyc,
                                            input int unsigned min_cyc,
                                            input int unsigned fixed_cyc);
    int unsigned settle;
    settle = live_taps * tap_cyc;
    if (settle < min_cyc) settle = min_cyc;
    return fixed_cyc + settle;
  endfunction

  // Index of the code bit under test after a given number of resolved bits.
  function automatic int unsigned bit_under_test(input int unsigned nbits,
                                                 input int unsigned resolved);
    return nbits - 1 - resolved;
  endfunction

endpackage

// File: rtl/sar_tap_chain.sv
module sar_tap_chain #(
  parameter int NBITS = 10,
  localparam int SW = (NBITS > 1) ? $clog2(NBITS) : 1,
  localparam int TCW = $clog2(NBITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restore,
  input  logic             drop,
  input  logic             keep_all,
  input  logic [SW-1:0]    drop_idx,
  output logic [TCW-1:0]   live_now,
  output logic [TCW-1:0]   live_next
);

  logic [NBITS-1:0] tap_q;
  logic [NBITS-1:0] tap_d;

  for (genvar i = 0; i < NBITS; i++) begin : g_tap
    always_comb begin
      if (restore) begin
        tap_d[i] = 1'b1;
      end else if (drop && !keep_all && (int'(drop_idx) == i)) begin
        tap_d[i] = 1'b0;
      end else begin
        tap_d[i] = tap_q[i];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tap_q[i] <= 1'b1;
      else        tap_q[i] <= tap_d[i];
    end
  end

  always_comb begin
    live_now  = '0;
    live_next = '0;
    for (int k = 0; k < NBITS; k++) begin
      live_now  = live_now  + TCW'(tap_q[k]);
      live_next = live_next + TCW'(tap_d[k]);
    end
  end

endmodule

// File: rtl/sar_settle_timer.sv
module sar_settle_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - TW'(1);
    end
  end

  assign expired = (cnt_q == TW'(1)) && !load;

endmodule

// File: rtl/sar_bit_reg.sv
module sar_bit_reg #(
  parameter int NBITS = 10,
  localparam int SW = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             decide,
  input  logic [SW-1:0]    resolved,
  input  logic             verdict,
  output logic [NBITS-1:0] code
);

  import sar_settle_pkg::*;

  logic [NBITS-1:0] code_d;
  int               pos;

  assign pos = int'(bit_under_test(NBITS, int'(resolved)));

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    always_comb begin
      code_d[i] = code[i];
      if (init) begin
        code_d[i] = (i == NBITS - 1);
      end else if (decide) begin
        if (i == pos)          code_d[i] = verdict;
        else if (i == pos - 1) code_d[i] = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code[i] <= 1'b0;
      else        code[i] <= code_d[i];
    end
  end

endmodule

// File: rtl/sar_settle_ctrl.sv
module sar_settle_ctrl #(
  parameter int NBITS     = 10,
  parameter int FIXED_CYC = 2,
  parameter int TAP_CYC   = 2,
  parameter int FLOOR_CYC = 5,
  parameter int CYCW      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_shrink,
  input  logic             cmp_valid,
  input  logic             cmp_result,
  output logic             cmp_req,
  output logic [NBITS-1:0] dac_code,
  output logic             busy,
  output logic             done,
  output logic [NBITS-1:0] result,
  output logic [CYCW-1:0]  conv_cycles
);

  import sar_settle_pkg::*;

  localparam int SW    = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam int TCW   = $clog2(NBITS + 1);
  localparam int MAXW  = FIXED_CYC + NBITS * TAP_CYC + FLOOR_CYC;
  localparam int TW    = $clog2(MAXW + 1);
  localparam logic [SW-1:0] LAST_STEP = SW'(NBITS - 1);

  sar_state_e       state_q;
  logic [SW-1:0]    step_q;
  logic             mode_q;
  logic             done_q;
  logic [NBITS-1:0] result_q;
  logic [CYCW-1:0]  cyc_q;

  // Named internal events, also used by the bound checker.
  logic             waiting;
  logic             wait_expired;
  logic             decision_taken;
  logic             last_decision;
  logic             timer_load;
  logic [TW-1:0]    timer_val;
  logic [TCW-1:0]   live_taps;
  logic [TCW-1:0]   live_taps_nxt;

  assign waiting        = (state_q == ST_SETTLE);
  assign decision_taken = (state_q == ST_ASK) && cmp_valid && !start;
  assign last_decision  = decision_taken && (step_q == LAST_STEP);
  assign timer_load     = start || (decision_taken && !last_decision);
  assign timer_val      = TW'(wait_span(int'(live_taps_nxt), TAP_CYC,
                                        FLOOR_CYC, FIXED_CYC));

  sar_tap_chain #(.NBITS(NBITS)) u_taps (
    .clk       (clk),
    .rst_n     (rst_n),
    .restore   (start),
    .drop      (decision_taken),
    .keep_all  (!mode_q),
    .drop_idx  (step_q),
    .live_now  (live_taps),
    .live_next (live_taps_nxt)
  );

  sar_settle_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (timer_val),
    .expired  (wait_expired)
  );

  sar_bit_reg #(.NBITS(NBITS)) u_bits (
    .clk      (clk),
    .rst_n    (rst_n),
    .init     (start),
    .decide   (decision_taken),
    .resolved (step_q),
    .verdict  (cmp_result),
    .code     (dac_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      step_q   <= '0;
      mode_q   <= 1'b1;
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        state_q <= ST_SETTLE;
        step_q  <= '0;
        mode_q  <= mode_shrink;
      end else begin
        unique case (state_q)
          ST_SETTLE: if (wait_expired) state_q <= ST_ASK;
          ST_ASK: begin
            if (last_decision) begin
              state_q  <= ST_IDLE;
              done_q   <= 1'b1;
              result_q <= {dac_code[NBITS-1:1], cmp_result};
            end else if (decision_taken) begin
              state_q <= ST_SETTLE;
              step_q  <= step_q + SW'(1);
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cyc_q <= '0;
    else if (start)             cyc_q <= '0;
    else if (state_q != ST_IDLE) cyc_q <= cyc_q + CYCW'(1);
  end

  assign cmp_req     = (state_q == ST_ASK);
  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign result      = result_q;
  assign conv_cycles = cyc_q;

endmodule

// File: rtl/sar_settle_chk.sv
module sar_settle_chk #(
  parameter int NBITS     = 10,
  parameter int FIXED_CYC = 2,
  parameter int TAP_CYC   = 2,
  parameter int FLOOR_CYC = 5,
  localparam int TCW = $clog2(NBITS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             cmp_valid,
  input logic             cmp_req,
  input logic             done,
  input logic             busy,
  input logic [NBITS-1:0] dac_code,
  input logic             mode_q,
  input logic             waiting,
  input logic             wait_expired,
  input logic             timer_load,
  input logic [TCW-1:0]   live_taps
);

  localparam logic [NBITS-1:0] MSB_ONLY = {1'b1, {(NBITS-1){1'b0}}};

  // Cycles spent in the current settling window, counted independently.
  logic [15:0] span_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          span_q <= '0;
    else if (timer_load) span_q <= '0;
    else if (waiting)    span_q <= span_q + 16'd1;
  end

  p_start_msb_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && dac_code == MSB_ONLY));

  p_req_after_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_req) |-> $past(wait_expired));

  p_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_expired && mode_q) |-> (int'(span_q) + 1 >= FIXED_CYC + FLOOR_CYC));

  p_worst_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_expired && !mode_q) |-> (int'(span_q) + 1 == FIXED_CYC + NBITS * TAP_CYC));

  p_worst_taps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mode_q) |-> (int'(live_taps) == NBITS));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_ignore_early_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && cmp_valid && !start) |=> $stable(dac_code));

endmodule

bind sar_settle_ctrl sar_settle_chk #(
  .NBITS(NBITS), .FIXED_CYC(FIXED_CYC), .TAP_CYC(TAP_CYC), .FLOOR_CYC(FLOOR_CYC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .cmp_valid    (cmp_valid),
  .cmp_req      (cmp_req),
  .done         (done),
  .busy         (busy),
  .dac_code     (dac_code),
  .mode_q       (mode_q),
  .waiting      (waiting),
  .wait_expired (wait_expired),
  .timer_load   (timer_load),
  .live_taps    (live_taps)
);

// File: tb/sar_settle_ctrl_bench.sv
module sar_settle_ctrl_bench;

  localparam int NB = 6;
  localparam int FX = 1;
  localparam int TP = 2;
  localparam int FL = 5;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          mode_shrink = 1'b1;
  logic          cmp_valid = 1'b0;
  logic          cmp_result = 1'b0;
  logic          cmp_req;
  logic [NB-1:0] dac_code;
  logic          busy;
  logic          done;
  logic [NB-1:0] result;
  logic [CW-1:0] conv_cycles;

  int checks = 0;
  int errors = 0;
  int last_cyc_shrink = 0;
  int last_cyc_worst = 0;

  always #4 clk = ~clk;

  sar_settle_ctrl #(
    .NBITS(NB), .FIXED_CYC(FX), .TAP_CYC(TP), .FLOOR_CYC(FL), .CYCW(CW)
  ) u_sar_settle_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_shrink(mode_shrink),
    .cmp_valid(cmp_valid), .cmp_result(cmp_result), .cmp_req(cmp_req),
    .dac_code(dac_code), .busy(busy), .done(done), .result(result),
    .conv_cycles(conv_cycles)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_wait(input int s, input bit shrink);
    int v;
    if (shrink) begin
      v = (NB - s) * TP;
      if (v < FL) v = FL;
    end else begin
      v = NB * TP;
    end
    return FX + v;
  endfunction

  function automatic int exp_total(input bit shrink);
    int t = 0;
    for (int s = 0; s < NB; s++) t += exp_wait(s, shrink) + 1;
    return t;
  endfunction

  // Caller is at a negedge.
  task automatic run_conv(input int vin, input bit shrink, input bit noise);
    int  cnt;
    bit  good;
    int  trial;
    start = 1'b1;
    mode_shrink = shrink;
    @(negedge clk);
    start = 1'b0;
    chk(busy && dac_code == NB'(1 << (NB - 1)), "R1 start loads MSB trial",
        int'(dac_code), 1 << (NB - 1));
    chk(conv_cycles == 0, "R1 cycle count cleared", int'(conv_cycles), 0);
    for (int s = 0; s < NB; s++) begin
      cnt = 0;
      while (!cmp_req && cnt < 1000) begin
        cnt++;
        if (noise) begin
          cmp_valid  = 1'b1;
          cmp_result = ~(vin >= int'(dac_code));
          mode_shrink = ~shrink;
        end
        @(negedge clk);
        cmp_valid = 1'b0;
      end
      if (noise)
        chk(cnt == exp_wait(s, shrink), "R10 R7 wait unchanged by mode flip and early valid",
            cnt, exp_wait(s, shrink));
      else if (shrink)
        chk(cnt == exp_wait(s, 1'b1), "R2 R3 shrinking wait", cnt, exp_wait(s, 1'b1));
      else
        chk(cnt == exp_wait(s, 1'b0), "R2 R4 worst-case wait", cnt, exp_wait(s, 1'b0));
      trial = (vin & ~((1 << (NB - s)) - 1)) | (1 << (NB - 1 - s));
      chk(int'(dac_code) == trial, "R5 trial code", int'(dac_code), trial);
      good = (vin >= int'(dac_code));
      cmp_valid  = 1'b1;
      cmp_result = good;
      @(negedge clk);
      cmp_valid = 1'b0;
    end
    mode_shrink = shrink;
    chk(done == 1'b1, "R6 done strobe", int'(done), 1);
    chk(int'(result) == vin, "R5 R6 final code", int'(result), vin);
    chk(int'(conv_cycles) == exp_total(shrink), "R9 conversion cycles",
        int'(conv_cycles), exp_total(shrink));
    if (shrink) last_cyc_shrink = int'(conv_cycles);
    else        last_cyc_worst  = int'(conv_cycles);
    @(negedge clk);
    chk(done == 1'b0, "R6 done lasts one cycle", int'(done), 0);
    chk(int'(result) == vin && !busy, "R6 result held", int'(result), vin);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !cmp_req && !done, "R1 idle after reset", int'(busy), 0);
    chk(dac_code == '0 && conv_cycles == '0, "R1 reset outputs", int'(dac_code), 0);

    for (int v = 0; v < (1 << NB); v++) run_conv(v, 1'b1, (v % 7) == 3);
    for (int v = 0; v < (1 << NB); v++) run_conv(v, 1'b0, (v % 9) == 4);

    run_conv(45, 1'b1, 1'b0);
    run_conv(45, 1'b0, 1'b0);
    chk(last_cyc_shrink < last_cyc_worst, "R9 shrinking mode is faster",
        last_cyc_shrink, last_cyc_worst);

    // Restart mid-conversion: start a shrinking conversion, leave it
    // waiting for a verdict, then start a worst-case one on top of it.
    start = 1'b1;
    mode_shrink = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    chk(busy == 1'b1, "R8 first conversion still running", int'(busy), 1);
    run_conv(22, 1'b0, 1'b0);
    chk(int'(result) == 22, "R8 restarted conversion result", int'(result), 22);

    finish_run();
  end

endmodule